// File: doc/BRIEF.md
# Byte-Coded Single-Cycle Processor Core

This block is a minimal processor that runs one single-byte instruction per clock cycle out of a private 32-entry instruction store. It holds four 8-bit working registers, a bank of four fixed 8-bit constants, a zero flag and a 5-bit program counter. Instructions come in four classes:

- a bit-mapped system class that drives the input, output, flag, fault and exit handshakes;
- a branch class with unconditional and zero-conditional forms;
- an ALU class with two register operands;
- an ALU class with a register operand and a constant operand.

Software loads the instruction store through a dedicated write port while reset is held. After reset is released, the core starts at address 0. The first instruction it executes must be a start marker; otherwise the core faults at once. Byte input uses a valid strobe and stalls the core until a byte arrives. Byte output and flag requests appear as single-cycle pulses. Fault and exit freeze the core until the next reset.

Top module: `byte_cpu_core`

## Requirements
- R1: Bits [1:0] select the class: 00 system, 10 branch, 01 register-register ALU, 11 register-constant ALU. For both ALU classes, bits [3:2] select the operation: 00 rotates operand 1 left by 5 bits and ignores operand 2, 01 is XOR, 10 is an 8-bit ADD with the carry dropped, 11 is AND.
- R2: In class 11, bits [7:6] pick a constant as operand 2: index 0 = 0x3F, 1 = 0xD5, 2 = 0x54, 3 = 0x00.
- R3: Bits [5:4] name the register that is both operand 1 and destination. In class 01, bits [7:6] name the operand-2 register.
- R4: Every ALU instruction sets the zero flag when its 8-bit result is zero and clears it otherwise. System and branch instructions leave the flag unchanged.
- R5: In the branch class, bits [7:3] are the target address. Bit 2 = 0 always jumps. Bit 2 = 1 jumps only when the zero flag is set and otherwise falls through to the next address.
- R6: The first instruction after reset must be a system instruction with bit 2 set. If it is not, `fault` rises on the next cycle and the PC stays where it is.
- R7: A system instruction with bit 3 set holds the PC and raises `in_wait` until `in_valid` is high at a clock edge. At that edge `in_data` is written to R0.
- R8: A system instruction with bit 4 set makes `out_valid` high for exactly one cycle, starting the cycle after it executes. `out_data` carries the value R3 held when the instruction executed.
- R9: A system instruction with bit 5 set makes `flag_req` high for one cycle, starting the cycle after it executes.
- R10: A system instruction with bit 6 sets `fault`, and one with bit 7 sets `exit_o`. Both stay set until reset. While either is set, the PC and all state stay frozen.
- R11: Sequential execution wraps the PC from 31 to 0.
- R12: During reset, the PC, registers and zero flag clear, and `out_valid`, `flag_req`, `fault` and `exit_o` are low.
- R13: `load_en` writes `load_data` into the instruction store at `load_addr` only while `rst` is high. When `rst` is low, `load_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables program loading |
| load_en | input | 1 | Instruction store write enable (honoured only in reset) |
| load_addr | input | 5 | Instruction store write address |
| load_data | input | 8 | Instruction store write byte |
| in_valid | input | 1 | Input byte is present |
| in_data | input | 8 | Input byte |
| in_wait | output | 1 | Core is stalled waiting for an input byte |
| out_valid | output | 1 | One-cycle output byte strobe |
| out_data | output | 8 | Output byte (R3 value) |
| flag_req | output | 1 | One-cycle flag request strobe |
| fault | output | 1 | Sticky fault/halt |
| exit_o | output | 1 | Sticky exit |
| pc_o | output | 5 | Current program counter |

## Verification
The bench builds the core with its default parameters: 8-bit data, four registers and a 5-bit PC. These values make the full 32-entry store small enough to reload before each test, and they make the 31-to-0 wrap reachable within a few cycles. With four registers, every register and constant index in the byte encoding can be exercised. Each ALU case runs a short loaded program that feeds two operand bytes, branches on the zero flag and reports the result through the output strobe. The result, the zero flag, the stall behaviour and the one-cycle pulse width are all read at the ports.

// File: rtl/byte_cpu_pkg.sv
package byte_cpu_pkg;

    localparam int DATA_W = 8;
    localparam int PC_W   = 5;
    localparam int NREG   = 4;
    localparam int RIDX_W = $clog2(NREG);

    typedef enum logic [1:0] {
        CLS_SYS    = 2'b00,
        CLS_ALU_RR = 2'b01,
        CLS_BRANCH = 2'b10,
        CLS_ALU_RI = 2'b11
    } op_class_e;

    typedef enum logic [1:0] {
        ALU_ROT5 = 2'b00,
        ALU_XOR  = 2'b01,
        ALU_ADD  = 2'b10,
        ALU_AND  = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic start;
        logic rd_in;
        logic wr_out;
        logic flag;
        logic halt;
        logic quit;
    } sys_bits_t;

    typedef struct packed {
        op_class_e         cls;
        alu_op_e           op;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs;
        logic [PC_W-1:0]   target;
        logic              cond;
        sys_bits_t         sys;
        logic              is_alu;
        logic              use_imm;
    } decoded_t;

    function automatic logic [DATA_W-1:0] const_bank(input logic [1:0] idx);
        case (idx)
            2'd0:    const_bank = 8'h3F;
            2'd1:    const_bank = 8'hD5;
            2'd2:    const_bank = 8'h54;
            default: const_bank = 8'h00;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] rotl5(input logic [DATA_W-1:0] v);
        rotl5 = {v[DATA_W-6:0], v[DATA_W-1:DATA_W-5]};
    endfunction

endpackage

// File: rtl/byte_cpu_decode.sv
module byte_cpu_decode
    import byte_cpu_pkg::*;
(
    input  logic [7:0] instr,
    output decoded_t   dec
);
    always_comb begin
        dec         = '0;
        dec.cls     = op_class_e'(instr[1:0]);
        dec.op      = alu_op_e'(instr[3:2]);
        dec.rd      = instr[5:4];
        dec.rs      = instr[7:6];
        dec.target  = instr[7:3];
        dec.cond    = instr[2];
        dec.is_alu  = instr[0];
        dec.use_imm = instr[1];
        if (instr[1:0] == CLS_SYS) begin
            dec.sys.start  = instr[2];
            dec.sys.rd_in  = instr[3];
            dec.sys.wr_out = instr[4];
            dec.sys.flag   = instr[5];
            dec.sys.halt   = instr[6];
            dec.sys.quit   = instr[7];
        end
    end
endmodule

// File: rtl/byte_cpu_regfile.sv
module byte_cpu_regfile
    import byte_cpu_pkg::*;
#(
    parameter int N      = NREG,
    parameter int W      = DATA_W,
    parameter int OUT_IX = N - 1,
    localparam int IW    = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] raddr_a,
    input  logic [IW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    output logic [W-1:0]  rdata_out
);
    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && waddr == IW'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata_a   = regs[raddr_a];
    assign rdata_b   = regs[raddr_b];
    assign rdata_out = regs[OUT_IX];
endmodule

// File: rtl/byte_cpu_alu.sv
module byte_cpu_alu
    import byte_cpu_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              zero
);
    always_comb begin
        case (op)
            ALU_ROT5: y = rotl5(a);
            ALU_XOR:  y = a ^ b;
            ALU_ADD:  y = a + b;
            default:  y = a & b;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/byte_cpu_core.sv
module byte_cpu_core
    import byte_cpu_pkg::*;
#(
    parameter int IMEM_AW = PC_W,
    localparam int IMEM_DEPTH = 1 << IMEM_AW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_en,
    input  logic [IMEM_AW-1:0] load_addr,
    input  logic [7:0]         load_data,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    output logic               in_wait,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic               flag_req,
    output logic               fault,
    output logic               exit_o,
    output logic [IMEM_AW-1:0] pc_o
);
    logic [7:0]         imem [IMEM_DEPTH];
    logic [IMEM_AW-1:0] pc_q;
    logic               started_q, zf_q, fault_q, exit_q;
    logic               outv_q, flag_q;
    logic [DATA_W-1:0]  outd_q;
    logic [7:0]         instr;
    decoded_t           dec;

    always_ff @(posedge clk) begin
        if (rst && load_en)
            imem[load_addr] <= load_data;
    end

    assign instr = imem[pc_q];

    byte_cpu_decode u_dec (.instr(instr), .dec(dec));

    logic halted, start_bad, is_sys, exec;
    assign halted    = fault_q | exit_q;
    assign is_sys    = (dec.cls == CLS_SYS);
    assign start_bad = !started_q && !(is_sys && dec.sys.start);
    assign in_wait   = !halted && !start_bad && is_sys && dec.sys.rd_in && !in_valid;
    assign exec      = !halted && !start_bad && !in_wait;

    logic [DATA_W-1:0] ra_val, rb_val, r3_val, opb, alu_y;
    logic              alu_z;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_waddr;
    logic [DATA_W-1:0] rf_wdata;

    assign opb = dec.use_imm ? const_bank(dec.rs) : rb_val;

    byte_cpu_alu u_alu (
        .op  (dec.op),
        .a   (ra_val),
        .b   (opb),
        .y   (alu_y),
        .zero(alu_z)
    );

    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = dec.rd;
        rf_wdata = alu_y;
        if (exec && dec.is_alu) begin
            rf_we = 1'b1;
        end else if (exec && is_sys && dec.sys.rd_in) begin
            rf_we    = 1'b1;
            rf_waddr = '0;
            rf_wdata = in_data;
        end
    end

    byte_cpu_regfile #(.N(NREG), .W(DATA_W), .OUT_IX(3)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .we       (rf_we),
        .waddr    (rf_waddr),
        .wdata    (rf_wdata),
        .raddr_a  (dec.rd),
        .raddr_b  (dec.rs),
        .rdata_a  (ra_val),
        .rdata_b  (rb_val),
        .rdata_out(r3_val)
    );

    logic               take_branch;
    logic [IMEM_AW-1:0] pc_next;
    always_comb begin
        take_branch = (dec.cls == CLS_BRANCH) && (!dec.cond || zf_q);
        pc_next     = take_branch ? IMEM_AW'(dec.target) : pc_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= '0;
            started_q <= 1'b0;
            zf_q      <= 1'b0;
            fault_q   <= 1'b0;
            exit_q    <= 1'b0;
            outv_q    <= 1'b0;
            flag_q    <= 1'b0;
            outd_q    <= '0;
        end else begin
            outv_q <= exec && is_sys && dec.sys.wr_out;
            flag_q <= exec && is_sys && dec.sys.flag;
            if (exec) begin
                pc_q      <= pc_next;
                started_q <= 1'b1;
                if (dec.is_alu)
                    zf_q <= alu_z;
                if (is_sys && dec.sys.wr_out)
                    outd_q <= r3_val;
                if (is_sys && dec.sys.halt)
                    fault_q <= 1'b1;
                if (is_sys && dec.sys.quit)
                    exit_q <= 1'b1;
            end else if (!halted && start_bad) begin
                fault_q <= 1'b1;
            end
        end
    end

    assign out_valid = outv_q;
    assign out_data  = outd_q;
    assign flag_req  = flag_q;
    assign fault     = fault_q;
    assign exit_o    = exit_q;
    assign pc_o      = pc_q;
endmodule

// File: rtl/byte_cpu_chk.sv
module byte_cpu_chk
    import byte_cpu_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            in_wait,
    input logic            fault,
    input logic            exit_o,
    input logic [PC_W-1:0] pc_o,
    input logic            started,
    input logic [7:0]      instr
);
    // R10
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    // R10
    exit_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        exit_o |=> exit_o);

    // R10
    halt_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (fault || exit_o) |=> $stable(pc_o));

    // R7
    stall_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (in_wait && !in_valid) |=> $stable(pc_o));

    // R6
    start_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (!started && !fault && !exit_o && !(instr[1:0] == 2'b00 && instr[2]))
        |=> (fault && $stable(pc_o)));

    // R12
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && !fault && !exit_o));
endmodule

bind byte_cpu_core byte_cpu_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_wait (in_wait),
    .fault   (fault),
    .exit_o  (exit_o),
    .pc_o    (pc_o),
    .started (started_q),
    .instr   (instr)
);

// File: tb/byte_cpu_core_tb.sv
module byte_cpu_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_en = 1'b0;
    logic [4:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_wait, out_valid, flag_req, fault, exit_o;
    logic [7:0] out_data;
    logic [4:0] pc_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    byte_cpu_core dut_i (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .in_valid(in_valid), .in_data(in_data),
        .in_wait(in_wait), .out_valid(out_valid), .out_data(out_data),
        .flag_req(flag_req), .fault(fault), .exit_o(exit_o), .pc_o(pc_o)
    );

    // vector: {imm, idx[1:0], op[1:0], a, b, expected, expected_zero}
    localparam int NV = 11;
    localparam logic [29:0] VEC [NV] = '{
        {1'b0, 2'd0, 2'd0, 8'h81, 8'h00, 8'h30, 1'b0},
        {1'b0, 2'd0, 2'd1, 8'h5A, 8'h5A, 8'h00, 1'b1},
        {1'b0, 2'd0, 2'd2, 8'hF0, 8'h20, 8'h10, 1'b0},
        {1'b0, 2'd0, 2'd2, 8'h80, 8'h80, 8'h00, 1'b1},
        {1'b0, 2'd0, 2'd3, 8'hCC, 8'h0F, 8'h0C, 1'b0},
        {1'b1, 2'd0, 2'd1, 8'h3F, 8'h99, 8'h00, 1'b1},
        {1'b1, 2'd1, 2'd2, 8'h01, 8'h99, 8'hD6, 1'b0},
        {1'b1, 2'd2, 2'd3, 8'hFF, 8'h99, 8'h54, 1'b0},
        {1'b1, 2'd3, 2'd1, 8'h77, 8'h99, 8'h77, 1'b0},
        {1'b0, 2'd0, 2'd0, 8'h00, 8'hFF, 8'h00, 1'b1},
        {1'b0, 2'd0, 2'd3, 8'hA5, 8'h5A, 8'h00, 1'b1}
    };

    logic [7:0] prog [32];
    logic [7:0] got_data;
    int         got_outs, got_flags;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 32; i++) prog[i] = 8'h00;
    endtask

    // hold reset and load the whole store (R13)
    task automatic load_and_start();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        for (int i = 0; i < 32; i++) begin
            load_en = 1'b1; load_addr = 5'(i); load_data = prog[i];
            @(negedge clk);
        end
        load_en = 1'b0;
        rst = 1'b0;
    endtask

    // run until exit/fault, feeding a then b to input requests
    task automatic run(input logic [7:0] a, input logic [7:0] b, input bit stall_test);
        int fed = 0;
        bit stalled_once = 0;
        got_outs = 0; got_flags = 0; got_data = '0;
        for (int cyc = 0; cyc < 200; cyc++) begin
            @(negedge clk);
            if (out_valid) begin got_outs++; got_data = out_data; end
            if (flag_req) got_flags++;
            if (exit_o || fault) break;
            if (in_wait) begin
                if (stall_test && !stalled_once) begin
                    logic [4:0] held = pc_o;
                    stalled_once = 1;
                    in_valid = 1'b0;
                    repeat (3) @(negedge clk);
                    // R7: PC holds while no input is offered
                    check(pc_o == held && in_wait, "R7", pc_o, held);
                end
                in_valid = 1'b1;
                in_data = (fed == 0) ? a : b;
                fed++;
            end else begin
                in_valid = 1'b0;
            end
        end
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [4:0] pc_hold;
        // R12: reset state
        repeat (3) @(negedge clk);
        check(pc_o == 0 && !out_valid && !flag_req && !fault && !exit_o, "R12", pc_o, 0);

        // ALU vectors (R1 R2 R3 R4 R5 R8 R9)
        for (int v = 0; v < NV; v++) begin
            logic [29:0] e = VEC[v];
            clear_prog();
            prog[0] = 8'h0C;                                  // START + input -> R0 = a
            prog[1] = 8'h15;                                  // R1 ^= R0
            prog[2] = 8'h08;                                  // input -> R0 = b
            prog[3] = {e[28:27], 2'b01, e[26:25], e[29], 1'b1}; // R1 op= R0 / const
            prog[4] = 8'h46;                                  // BZ 8
            prog[5] = 8'h75;                                  // R3 ^= R1
            prog[6] = 8'h90;                                  // out + exit
            prog[8] = 8'h75;
            prog[9] = 8'hB0;                                  // out + flag + exit
            load_and_start();
            run(e[24:17], e[16:9], v == 0);
            // R1 R2 R3: result via R3
            check(got_data == e[8:1], e[29] ? "R2" : "R1", got_data, e[8:1]);
            // R4 R5 R9: zero flag steers BZ, flag only on taken path
            check((got_flags == 1) == e[0], "R4", got_flags, e[0]);
            // R8: exactly one output pulse
            check(got_outs == 1, "R8", got_outs, 1);
        end

        // R10: exit sticky, PC frozen
        pc_hold = pc_o;
        repeat (4) @(negedge clk);
        check(exit_o && pc_o == pc_hold, "R10", pc_o, pc_hold);

        // R4: non-ALU instructions keep the zero flag
        clear_prog();
        prog[0] = 8'h0C; prog[1] = 8'h15; prog[2] = 8'h10;
        prog[3] = 8'h46; prog[4] = 8'h80; prog[8] = 8'hA0;
        load_and_start();
        run(8'h00, 8'h00, 0);
        check(got_flags == 1, "R4", got_flags, 1);

        // R6: missing START faults, PC stays
        clear_prog();
        prog[0] = 8'h15;
        load_and_start();
        repeat (4) @(negedge clk);
        check(fault && pc_o == 0, "R6", {fault, pc_o}, 32'h20);

        // R10: halt bit sets sticky fault
        clear_prog();
        prog[0] = 8'h04; prog[1] = 8'h40;
        load_and_start();
        repeat (5) @(negedge clk);
        check(fault && !exit_o && pc_o == 2, "R10", pc_o, 2);

        // R5 R11: unconditional jump to 30 then wrap
        clear_prog();
        prog[0] = 8'h04; prog[1] = 8'hF2;
        load_and_start();
        @(negedge clk); @(negedge clk);
        check(pc_o == 30, "R5", pc_o, 30);
        @(negedge clk); @(negedge clk);
        check(pc_o == 0, "R11", pc_o, 0);

        // R13: load outside reset ignored
        clear_prog();
        prog[0] = 8'h04; prog[1] = 8'h0A; prog[2] = 8'h80;
        load_and_start();
        repeat (3) @(negedge clk);
        load_en = 1'b1; load_addr = 5'd1; load_data = 8'h80;
        @(negedge clk);
        load_en = 1'b0;
        repeat (4) @(negedge clk);
        check(!exit_o && pc_o == 1, "R13", pc_o, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule